// File: doc/BRIEF.md
# Ratchet-Gated Secure Memory Firewall

This block sits between a processor bus and two protected memories: a rewritable code store and a battery-backed secret RAM divided into one page per software layer. It holds a small privilege counter, the ratchet, that software can only step upward and that only a reset brings back to zero. Every bus request is decoded to a region and checked against the current ratchet value. A forbidden request never reaches a memory. Instead, the requester receives an error response with zero data, and the offending address is latched for later inspection.

A tamper input starts a hardware sequencer. The sequencer writes zero into every word of the secret RAM, one word per clock, and the secret RAM stays closed to the bus until the wipe is done. A sticky tamper flag records the event. This flag survives ordinary resets and is cleared only by a separate power-on reset.

Boot firmware runs at ratchet 0. Each layer steps the ratchet up before it hands control to the next layer. From then on, the hardware keeps a less privileged layer away from the secrets and code of the layers below it.

Top module: `ratchet_fw`

## Requirements
- R1: While `rst_ni` or `por_ni` is low, the ratchet reads 0, the overflow bit and the fault address register are cleared, and `rsp_valid_o` and `err_o` are low.
- R2: Each accepted write to the ratchet register (register block offset 0) raises the ratchet by exactly one. No bus operation ever lowers the ratchet.
- R3: The ratchet is RW bits wide and saturates at its maximum (7 by default). An increment at the maximum leaves the value unchanged and sets the sticky overflow flag, which is status bit 1.
- R4: A code-store write is forwarded only while the ratchet is 0 or 1. Code-store reads are forwarded at any ratchet value.
- R5: The secret RAM starts at address 0. Page N covers bytes N*PAGE_BYTES up to (N+1)*PAGE_BYTES-1 for N below NUM_FULL, and the last page is LAST_BYTES long. Page N is readable and writable only while the ratchet is less than or equal to N.
- R6: For a denied request, the chip select and write enable of the code store are low in that cycle. The same holds for the secret RAM, except while the wipe is driving it.
- R7: One cycle after any request, `rsp_valid_o` is high for one cycle. If the request was denied, `err_o` is high in that same cycle, `rdata_o` is zero, and the fault address register (register block offset 8) holds the denied address.
- R8: An address outside the secret RAM, the code store and the three registers is denied.
- R9: A rising edge on `tamper_i` starts the wipe. The wipe writes zero to each secret RAM word, one word per clock, for exactly SEC_WORDS cycles. Status bit 2 is high while the wipe runs, and every secret RAM request is denied during that time.
- R10: The tamper flag (status bit 0) is set by a tamper edge. It stays set through `rst_ni` and clears only on `por_ni`. A pulse on `rst_ni` does not stop a wipe that is in progress.
- R11: The ratchet (offset 0), status (offset 4) and fault address (offset 8) registers are readable at every ratchet value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Ordinary asynchronous reset, active low |
| por_ni | input | 1 | Power-on asynchronous reset, active low; also clears tamper state |
| tamper_i | input | 1 | Tamper detector; a rising edge starts the wipe |
| req_i | input | 1 | Bus request strobe |
| we_i | input | 1 | Request is a write |
| addr_i | input | AW | Byte address |
| wdata_i | input | DW | Write data |
| rsp_valid_o | output | 1 | Response strobe, one cycle after the request |
| err_o | output | 1 | Request was denied |
| rdata_o | output | DW | Read data, zero on denial or write |
| sec_cs_o | output | 1 | Secret RAM chip select |
| sec_we_o | output | 1 | Secret RAM write enable |
| sec_addr_o | output | SEC_AW | Secret RAM word address |
| sec_wdata_o | output | DW | Secret RAM write data |
| sec_rdata_i | input | DW | Secret RAM read data, one cycle after select |
| code_cs_o | output | 1 | Code store chip select |
| code_we_o | output | 1 | Code store write enable |
| code_addr_o | output | CODE_AW | Code store word address |
| code_wdata_o | output | DW | Code store write data |
| code_rdata_i | input | DW | Code store read data, one cycle after select |

## Verification
The bench builds the block with 64-byte pages, a 32-byte last page and a 256-byte code store. With these values the secret RAM is only 136 words, so a full wipe, with its exact cycle count and its interaction with an ordinary reset, fits in a short run. The ratchet keeps its default 3-bit width. This brings within reach the first and last byte of several pages, the short final page, the address just past it, the step from ratchet 1 to 2 that locks the code store, and saturation at 7.

// File: rtl/fw_pkg.sv
package fw_pkg;
  typedef enum logic [2:0] {
    RG_NONE  = 3'd0,
    RG_SEC   = 3'd1,
    RG_CODE  = 3'd2,
    RG_RAT   = 3'd3,
    RG_STAT  = 3'd4,
    RG_FAULT = 3'd5
  } region_e;

  localparam int ST_TAMPER = 0;
  localparam int ST_OVF    = 1;
  localparam int ST_BUSY   = 2;
endpackage

// File: rtl/fw_decode.sv
module fw_decode
  import fw_pkg::*;
#(
  parameter int AW         = 16,
  parameter int DW         = 32,
  parameter int RW         = 3,
  parameter int PAGE_BYTES = 1024,
  parameter int NUM_FULL   = 8,
  parameter int LAST_BYTES = 512,
  parameter int CODE_BASE  = 'h8000,
  parameter int CODE_BYTES = 4096,
  parameter int REG_BASE   = 'hF000,
  parameter int SEC_AW     = 12,
  parameter int CODE_AW    = 10
) (
  input  logic [AW-1:0]      addr_i,
  input  logic               we_i,
  input  logic [RW-1:0]      ratchet_i,
  input  logic               zbusy_i,
  output region_e            region_o,
  output logic               allow_o,
  output logic [SEC_AW-1:0]  sec_addr_o,
  output logic [CODE_AW-1:0] code_addr_o
);
  localparam int BO        = $clog2(DW/8);
  localparam int PAGE_SH   = $clog2(PAGE_BYTES);
  localparam int SEC_BYTES = NUM_FULL*PAGE_BYTES + LAST_BYTES;
  localparam int REG_WORD  = REG_BASE >> BO;

  int a;
  int page;
  int wrd;

  always_comb begin
    a        = int'(addr_i);
    page     = a >> PAGE_SH;
    wrd      = a >> BO;
    region_o = RG_NONE;
    allow_o  = 1'b0;
    if (a < SEC_BYTES) begin
      region_o = RG_SEC;
      allow_o  = !zbusy_i && (int'(ratchet_i) <= page);
    end else if (a >= CODE_BASE && a < CODE_BASE + CODE_BYTES) begin
      region_o = RG_CODE;
      allow_o  = !we_i || (int'(ratchet_i) <= 1);
    end else if (wrd == REG_WORD) begin
      region_o = RG_RAT;
      allow_o  = 1'b1;
    end else if (wrd == REG_WORD + 1) begin
      region_o = RG_STAT;
      allow_o  = 1'b1;
    end else if (wrd == REG_WORD + 2) begin
      region_o = RG_FAULT;
      allow_o  = 1'b1;
    end
  end

  assign sec_addr_o  = SEC_AW'(a >> BO);
  assign code_addr_o = CODE_AW'((a - CODE_BASE) >> BO);
endmodule

// File: rtl/fw_ratchet.sv
module fw_ratchet #(
  parameter int RW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          inc_i,
  output logic [RW-1:0] ratchet_o,
  output logic          ovf_o
);
  localparam logic [RW-1:0] TOP = '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ratchet_o <= '0;
      ovf_o     <= 1'b0;
    end else if (inc_i) begin
      if (ratchet_o == TOP) ovf_o <= 1'b1;
      else                  ratchet_o <= ratchet_o + 1'b1;
    end
  end
endmodule

// File: rtl/fw_zeroize.sv
module fw_zeroize #(
  parameter int SEC_WORDS = 2176,
  parameter int SEC_AW    = 12
) (
  input  logic              clk_i,
  input  logic              por_ni,
  input  logic              tamper_i,
  output logic              busy_o,
  output logic [SEC_AW-1:0] waddr_o,
  output logic              tflag_o
);
  localparam logic [SEC_AW-1:0] LAST = SEC_AW'(SEC_WORDS - 1);

  logic t_prev;

  // only power-on reset: an ordinary reset must not abort a wipe
  always_ff @(posedge clk_i or negedge por_ni) begin
    if (!por_ni) begin
      t_prev  <= 1'b0;
      busy_o  <= 1'b0;
      waddr_o <= '0;
      tflag_o <= 1'b0;
    end else begin
      t_prev <= tamper_i;
      if (tamper_i && !t_prev) begin
        busy_o  <= 1'b1;
        waddr_o <= '0;
        tflag_o <= 1'b1;
      end else if (busy_o) begin
        if (waddr_o == LAST) busy_o <= 1'b0;
        else                 waddr_o <= waddr_o + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ratchet_fw.sv
module ratchet_fw
  import fw_pkg::*;
#(
  parameter int AW         = 16,
  parameter int DW         = 32,
  parameter int RW         = 3,
  parameter int PAGE_BYTES = 1024,
  parameter int NUM_FULL   = 8,
  parameter int LAST_BYTES = 512,
  parameter int CODE_BASE  = 'h8000,
  parameter int CODE_BYTES = 4096,
  parameter int REG_BASE   = 'hF000,
  localparam int SEC_WORDS = (NUM_FULL*PAGE_BYTES + LAST_BYTES) / (DW/8),
  localparam int SEC_AW    = $clog2(SEC_WORDS),
  localparam int CODE_AW   = $clog2(CODE_BYTES / (DW/8))
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               por_ni,
  input  logic               tamper_i,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [AW-1:0]      addr_i,
  input  logic [DW-1:0]      wdata_i,
  output logic               rsp_valid_o,
  output logic               err_o,
  output logic [DW-1:0]      rdata_o,
  output logic               sec_cs_o,
  output logic               sec_we_o,
  output logic [SEC_AW-1:0]  sec_addr_o,
  output logic [DW-1:0]      sec_wdata_o,
  input  logic [DW-1:0]      sec_rdata_i,
  output logic               code_cs_o,
  output logic               code_we_o,
  output logic [CODE_AW-1:0] code_addr_o,
  output logic [DW-1:0]      code_wdata_o,
  input  logic [DW-1:0]      code_rdata_i
);
  logic               sys_rst_n;
  region_e            dec_region;
  logic               dec_allow;
  logic [SEC_AW-1:0]  dec_sec_addr;
  logic [CODE_AW-1:0] dec_code_addr;
  logic [RW-1:0]      ratchet_q;
  logic               ovf_q;
  logic               zbusy;
  logic               tflag;
  logic [SEC_AW-1:0]  zaddr;
  logic               fwd;
  logic               inc;
  logic [AW-1:0]      fault_q;
  logic               rsp_q;
  logic               err_q;
  region_e            rsel_q;
  logic [DW-1:0]      rreg_q;
  logic [DW-1:0]      status;
  logic [DW-1:0]      reg_val;

  assign sys_rst_n = rst_ni & por_ni;

  fw_decode #(
    .AW(AW), .DW(DW), .RW(RW), .PAGE_BYTES(PAGE_BYTES), .NUM_FULL(NUM_FULL),
    .LAST_BYTES(LAST_BYTES), .CODE_BASE(CODE_BASE), .CODE_BYTES(CODE_BYTES),
    .REG_BASE(REG_BASE), .SEC_AW(SEC_AW), .CODE_AW(CODE_AW)
  ) u_dec (
    .addr_i     (addr_i),
    .we_i       (we_i),
    .ratchet_i  (ratchet_q),
    .zbusy_i    (zbusy),
    .region_o   (dec_region),
    .allow_o    (dec_allow),
    .sec_addr_o (dec_sec_addr),
    .code_addr_o(dec_code_addr)
  );

  assign fwd = req_i && dec_allow;
  assign inc = fwd && we_i && (dec_region == RG_RAT);

  fw_ratchet #(.RW(RW)) u_rat (
    .clk_i    (clk_i),
    .rst_ni   (sys_rst_n),
    .inc_i    (inc),
    .ratchet_o(ratchet_q),
    .ovf_o    (ovf_q)
  );

  fw_zeroize #(.SEC_WORDS(SEC_WORDS), .SEC_AW(SEC_AW)) u_zero (
    .clk_i   (clk_i),
    .por_ni  (por_ni),
    .tamper_i(tamper_i),
    .busy_o  (zbusy),
    .waddr_o (zaddr),
    .tflag_o (tflag)
  );

  // memory side: the wipe owns the secret RAM while it runs
  assign sec_cs_o     = zbusy || (fwd && dec_region == RG_SEC);
  assign sec_we_o     = zbusy || (fwd && dec_region == RG_SEC && we_i);
  assign sec_addr_o   = zbusy ? zaddr : dec_sec_addr;
  assign sec_wdata_o  = zbusy ? '0 : wdata_i;
  assign code_cs_o    = fwd && dec_region == RG_CODE;
  assign code_we_o    = fwd && dec_region == RG_CODE && we_i;
  assign code_addr_o  = dec_code_addr;
  assign code_wdata_o = wdata_i;

  always_comb begin
    status            = '0;
    status[ST_TAMPER] = tflag;
    status[ST_OVF]    = ovf_q;
    status[ST_BUSY]   = zbusy;
    unique case (dec_region)
      RG_RAT:   reg_val = DW'(ratchet_q);
      RG_STAT:  reg_val = status;
      RG_FAULT: reg_val = DW'(fault_q);
      default:  reg_val = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge sys_rst_n) begin
    if (!sys_rst_n) begin
      rsp_q   <= 1'b0;
      err_q   <= 1'b0;
      rsel_q  <= RG_NONE;
      rreg_q  <= '0;
      fault_q <= '0;
    end else begin
      rsp_q  <= req_i;
      err_q  <= req_i && !dec_allow;
      rsel_q <= (fwd && !we_i) ? dec_region : RG_NONE;
      rreg_q <= reg_val;
      if (req_i && !dec_allow) fault_q <= addr_i;
    end
  end

  assign rsp_valid_o = rsp_q;
  assign err_o       = err_q;

  always_comb begin
    unique case (rsel_q)
      RG_SEC:                    rdata_o = sec_rdata_i;
      RG_CODE:                   rdata_o = code_rdata_i;
      RG_RAT, RG_STAT, RG_FAULT: rdata_o = rreg_q;
      default:                   rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/fw_checker.sv
module fw_checker #(
  parameter int AW         = 16,
  parameter int DW         = 32,
  parameter int RW         = 3,
  parameter int SEC_AW     = 12,
  parameter int PAGE_BYTES = 1024
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              por_ni,
  input logic              req_i,
  input logic [AW-1:0]     addr_i,
  input logic              rsp_valid_o,
  input logic              err_o,
  input logic [DW-1:0]     rdata_o,
  input logic              sec_cs_o,
  input logic              sec_we_o,
  input logic [SEC_AW-1:0] sec_addr_o,
  input logic [DW-1:0]     sec_wdata_o,
  input logic              code_cs_o,
  input logic              code_we_o,
  input logic [RW-1:0]     ratchet_i,
  input logic              ovf_i,
  input logic              allow_i,
  input logic              zbusy_i,
  input logic              tflag_i,
  input logic [AW-1:0]     fault_i
);
  localparam int BO      = $clog2(DW/8);
  localparam int PAGE_SH = $clog2(PAGE_BYTES);
  localparam logic [RW-1:0] TOP = '1;

  p_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    1 |=> (ratchet_i == $past(ratchet_i)) || (ratchet_i == $past(ratchet_i) + 1'b1 && ratchet_i != '0));

  p_sat_r3: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    ratchet_i == TOP |=> ratchet_i == TOP);

  p_ovf_sticky_r3: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    ovf_i |=> ovf_i);

  p_code_lock_r4: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    code_we_o |-> int'(ratchet_i) <= 1);

  p_sec_page_r5: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    sec_cs_o && !zbusy_i |-> int'(ratchet_i) <= (int'(sec_addr_o) >> (PAGE_SH - BO)));

  p_deny_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    req_i && !allow_i |-> !code_cs_o && !code_we_o && (zbusy_i || (!sec_cs_o && !sec_we_o)));

  p_deny_rsp_r7: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    req_i && !allow_i |=> rsp_valid_o && err_o && rdata_o == '0 && fault_i == $past(addr_i));

  p_err_valid_r7: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    err_o |-> rsp_valid_o);

  p_wipe_zero_r9: assert property (@(posedge clk_i) disable iff (!por_ni)
    zbusy_i |-> sec_cs_o && sec_we_o && sec_wdata_o == '0);

  p_tflag_sticky_r10: assert property (@(posedge clk_i) disable iff (!por_ni)
    tflag_i |=> tflag_i);

  p_busy_flag_r10: assert property (@(posedge clk_i) disable iff (!por_ni)
    zbusy_i |-> tflag_i);
endmodule

bind ratchet_fw fw_checker #(
  .AW(AW), .DW(DW), .RW(RW), .SEC_AW(SEC_AW), .PAGE_BYTES(PAGE_BYTES)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .por_ni     (por_ni),
  .req_i      (req_i),
  .addr_i     (addr_i),
  .rsp_valid_o(rsp_valid_o),
  .err_o      (err_o),
  .rdata_o    (rdata_o),
  .sec_cs_o   (sec_cs_o),
  .sec_we_o   (sec_we_o),
  .sec_addr_o (sec_addr_o),
  .sec_wdata_o(sec_wdata_o),
  .code_cs_o  (code_cs_o),
  .code_we_o  (code_we_o),
  .ratchet_i  (ratchet_q),
  .ovf_i      (ovf_q),
  .allow_i    (dec_allow),
  .zbusy_i    (zbusy),
  .tflag_i    (tflag),
  .fault_i    (fault_q)
);

// File: tb/sim_ratchet_fw.sv
`timescale 1ns/1ps
module sim_ratchet_fw;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int PB = 64;
  localparam int NF = 8;
  localparam int LB = 32;
  localparam int CB = 256;
  localparam int SW = (NF*PB + LB) / 4;
  localparam int SAW = $clog2(SW);
  localparam int CW = CB / 4;
  localparam int CAW = $clog2(CW);
  localparam int NV = 23;

  logic clk = 1'b0;
  logic rst_ni = 1'b0, por_ni = 1'b0, tamper = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic rsp_valid, err;
  logic [DW-1:0] rdata;
  logic sec_cs, sec_we, code_cs, code_we;
  logic [SAW-1:0] sec_addr;
  logic [CAW-1:0] code_addr;
  logic [DW-1:0] sec_wdata, code_wdata, s_rd, c_rd;
  logic [DW-1:0] smem [SW];
  logic [DW-1:0] cmem [CW];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ratchet_fw #(
    .AW(AW), .DW(DW), .RW(3), .PAGE_BYTES(PB), .NUM_FULL(NF), .LAST_BYTES(LB),
    .CODE_BASE('h8000), .CODE_BYTES(CB), .REG_BASE('hF000)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .por_ni(por_ni), .tamper_i(tamper),
    .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rsp_valid_o(rsp_valid), .err_o(err), .rdata_o(rdata),
    .sec_cs_o(sec_cs), .sec_we_o(sec_we), .sec_addr_o(sec_addr),
    .sec_wdata_o(sec_wdata), .sec_rdata_i(s_rd),
    .code_cs_o(code_cs), .code_we_o(code_we), .code_addr_o(code_addr),
    .code_wdata_o(code_wdata), .code_rdata_i(c_rd)
  );

  // memory models, one-cycle read latency
  always @(posedge clk) begin
    if (sec_cs) begin
      if (sec_we) smem[int'(sec_addr)] <= sec_wdata;
      else        s_rd <= smem[int'(sec_addr)];
    end
    if (code_cs) begin
      if (code_we) cmem[int'(code_addr)] <= code_wdata;
      else         c_rd <= cmem[int'(code_addr)];
    end
  end

  // {req tag, we, addr, wdata, exp_err, exp_rdata, check_rdata}
  localparam logic [86:0] TBL [NV] = '{
    {4'd5,  1'b1, 16'h0000, 32'hA000_0000, 1'b0, 32'h0, 1'b0},          // R5 page 0 at ratchet 0
    {4'd5,  1'b1, 16'h01C0, 32'hA000_0007, 1'b0, 32'h0, 1'b0},          // R5 page 7 first byte
    {4'd5,  1'b1, 16'h0200, 32'hA000_0008, 1'b0, 32'h0, 1'b0},          // R5 short last page
    {4'd4,  1'b1, 16'h8010, 32'hC000_0001, 1'b0, 32'h0, 1'b0},          // R4
    {4'd4,  1'b1, 16'h8018, 32'hC000_0000, 1'b0, 32'h0, 1'b0},          // R4
    {4'd5,  1'b0, 16'h0000, 32'h0,         1'b0, 32'hA000_0000, 1'b1},  // R5
    {4'd4,  1'b0, 16'h8010, 32'h0,         1'b0, 32'hC000_0001, 1'b1},  // R4
    {4'd2,  1'b1, 16'hF000, 32'h0,         1'b0, 32'h0, 1'b0},          // R2 step to 1
    {4'd11, 1'b0, 16'hF000, 32'h0,         1'b0, 32'h1, 1'b1},          // R11
    {4'd4,  1'b1, 16'h8014, 32'hC000_0002, 1'b0, 32'h0, 1'b0},          // R4 write at 1
    {4'd5,  1'b0, 16'h0000, 32'h0,         1'b1, 32'h0, 1'b1},          // R5 page 0 locked
    {4'd2,  1'b1, 16'hF000, 32'h0,         1'b0, 32'h0, 1'b0},          // R2 step to 2
    {4'd4,  1'b1, 16'h8018, 32'hC000_0003, 1'b1, 32'h0, 1'b0},          // R4 write at 2 denied
    {4'd4,  1'b0, 16'h8014, 32'h0,         1'b0, 32'hC000_0002, 1'b1},  // R4 read at 2
    {4'd4,  1'b0, 16'h8018, 32'h0,         1'b0, 32'hC000_0000, 1'b1},  // R4 old value kept
    {4'd7,  1'b0, 16'hF008, 32'h0,         1'b0, 32'h0000_8018, 1'b1},  // R7 fault address
    {4'd5,  1'b0, 16'h01C0, 32'h0,         1'b0, 32'hA000_0007, 1'b1},  // R5
    {4'd5,  1'b1, 16'h007C, 32'h0,         1'b1, 32'h0, 1'b0},          // R5 page 1 last word
    {4'd8,  1'b0, 16'h4000, 32'h0,         1'b1, 32'h0, 1'b1},          // R8 unmapped
    {4'd8,  1'b0, 16'h0220, 32'h0,         1'b1, 32'h0, 1'b1},          // R8 past last page
    {4'd5,  1'b0, 16'h0200, 32'h0,         1'b0, 32'hA000_0008, 1'b1},  // R5
    {4'd11, 1'b0, 16'hF004, 32'h0,         1'b0, 32'h0, 1'b1},          // R11 status
    {4'd7,  1'b0, 16'hF008, 32'h0,         1'b0, 32'h0000_0220, 1'b1}   // R7
  };

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic acc(input logic w, input logic [AW-1:0] a, input logic [DW-1:0] d,
                     output logic v, output logic e, output logic [DW-1:0] r, output logic fw);
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d;
    #1;
    fw = code_cs | code_we | sec_cs | sec_we;
    @(negedge clk);
    v = rsp_valid; e = err; r = rdata;
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [AW-1:0] a, input logic exp_e, input logic [DW-1:0] exp_r);
    logic v, e, fw;
    logic [DW-1:0] r;
    acc(1'b0, a, '0, v, e, r, fw);
    chk({tag, " valid"}, DW'(v), 1);
    chk({tag, " err"}, DW'(e), DW'(exp_e));
    chk({tag, " data"}, r, exp_r);
  endtask

  task automatic incr(input string tag);
    logic v, e, fw;
    logic [DW-1:0] r;
    acc(1'b1, 16'hF000, '0, v, e, r, fw);
    chk(tag, DW'(e), 0);
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    if (which == 0) rst_ni = 1'b0;
    else if (which == 1) por_ni = 1'b0;
    else tamper = 1'b1;
    @(negedge clk);
    rst_ni = 1'b1; por_ni = 1'b1; tamper = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic v, e, fw;
    logic [DW-1:0] r;
    int cnt;
    repeat (3) @(negedge clk);
    chk("R1 rsp_valid in reset", DW'(rsp_valid), 0);
    chk("R1 err in reset", DW'(err), 0);
    rst_ni = 1'b1; por_ni = 1'b1;
    rd("R1 ratchet after reset", 16'hF000, 1'b0, 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic [86:0] t;
      string tg;
      t = TBL[i];
      tg = $sformatf("R%0d row %0d", int'(t[86:83]), i);
      acc(t[82], t[81:66], t[65:34], v, e, r, fw);
      chk({tg, " valid"}, DW'(v), 1);
      chk({tg, " err"}, DW'(e), DW'(t[33]));
      if (t[0]) chk({tg, " data"}, r, t[32:1]);
      if (t[33]) chk($sformatf("R6 row %0d mem select", i), DW'(fw), 0);
    end

    // R2 / R3 climb to saturation
    for (int k = 0; k < 5; k++) incr("R2 increment");
    rd("R2 ratchet at top", 16'hF000, 1'b0, 32'h7);
    rd("R3 no overflow yet", 16'hF004, 1'b0, 32'h0);
    incr("R3 increment at top");
    rd("R3 saturated", 16'hF000, 1'b0, 32'h7);
    rd("R3 overflow bit", 16'hF004, 1'b0, 32'h2);
    rd("R5 page 7 at ratchet 7", 16'h01C0, 1'b0, 32'hA000_0007);
    rd("R5 page 6 at ratchet 7", 16'h01BC, 1'b1, 32'h0);
    rd("R11 fault at ratchet 7", 16'hF008, 1'b0, 32'h0000_01BC);

    pulse(0);
    rd("R1 ratchet cleared", 16'hF000, 1'b0, 32'h0);
    rd("R1 status cleared", 16'hF004, 1'b0, 32'h0);
    rd("R1 fault cleared", 16'hF008, 1'b0, 32'h0);
    rd("R5 page 0 reopened", 16'h0000, 1'b0, 32'hA000_0000);

    // R9 wipe length and content
    @(negedge clk); tamper = 1'b1;
    @(negedge clk); tamper = 1'b0;
    cnt = 0;
    while (sec_we && sec_wdata == '0 && cnt < 1000) begin cnt++; @(negedge clk); end
    chk("R9 wipe cycles", DW'(cnt), DW'(SW));
    begin
      int nz;
      nz = 0;
      for (int k = 0; k < SW; k++) if (smem[k] !== '0) nz++;
      chk("R9 words left nonzero", DW'(nz), 0);
    end
    rd("R10 tamper flag", 16'hF004, 1'b0, 32'h1);
    rd("R9 access after wipe", 16'h0200, 1'b0, 32'h0);

    // R9 blocked while busy, R10 rst_ni does not stop it
    acc(1'b1, 16'h0000, 32'h0000_0055, v, e, r, fw);
    chk("R9 write before second tamper", DW'(e), 0);
    pulse(2);
    rd("R9 denied while busy", 16'h0000, 1'b1, 32'h0);
    rd("R9 busy status", 16'hF004, 1'b0, 32'h5);
    pulse(0);
    cnt = 0;
    while (sec_we && cnt < 1000) begin cnt++; @(negedge clk); end
    rd("R10 wipe survived reset", 16'h0000, 1'b0, 32'h0);
    rd("R10 flag survives rst_ni", 16'hF004, 1'b0, 32'h1);

    pulse(1);
    rd("R10 flag cleared by por_ni", 16'hF004, 1'b0, 32'h0);
    rd("R1 ratchet after por", 16'hF000, 1'b0, 32'h0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule